// File: doc/BRIEF.md
# Host Interrupt Aggregation Controller

This block gathers up to eighteen internal event sources into one sticky status vector. It masks that vector bit by bit and drives a single interrupt line toward the host processor. Each source is a one-cycle pulse. The pulse sets its status bit, and the bit stays set until the host retires it. The host can retire bits in two ways: by writing ones to an acknowledge register, or by reading a status view that clears itself on the read.

A small register port gives the host access to the block. It has one address, a read strobe, a write strobe, and a write-data and read-data bus. Through it the host reaches:
- the mask, which can be written as a whole or changed bit by bit through set and clear registers, without a read-modify-write;
- two views of the status, one that has no side effects and one that clears on read;
- the acknowledge register;
- a two-bit pin configuration that enables the line and selects its polarity.

Top module: `host_irq_agg`

## Requirements
- R1: Only source positions 0 to 10, 14, 16 and 17 are implemented (valid map 0x347FF). Pulses on positions 11, 12, 13 and 15 are ignored, and those bits always read as zero in the status and mask registers.
- R2: The register offsets are as follows:
  - 0: mask, read/write
  - 1: mask set
  - 2: mask clear
  - 3: status view with no side effects
  - 4: status view that clears on read
  - 5: acknowledge
  - 6: pin configuration

  Read data appears on `rdata_o` in the cycle after the read strobe, zero-extended. It is zero in every cycle that follows no read. A read of offsets 1, 2, 5 or 7 returns zero.
- R3: A mask bit of 1 blocks its source from the host line, and 0 passes it. The mask resets to 0x00001. A full write at offset 0 loads the written value, limited to the valid map.
- R4: A write at offset 1 ORs the written value into the mask. Zero bits leave their mask bits unchanged.
- R5: A write at offset 2 clears every mask bit written as 1. Zero bits leave their mask bits unchanged.
- R6: A read at offset 3 returns the current status and changes no state.
- R7: A read at offset 4 returns the current status and clears every status bit at the same clock edge.
- R8: A write at offset 5 clears the status bits written as 1. Both status views reflect the change from the next cycle.
- R9: Status bits are sticky: they hold until they are cleared. When a source pulse and a clear (acknowledge or clear-on-read) hit the same bit in the same cycle, the bit ends set.
- R10: The pin configuration has two bits:
  - Bit 0 enables the line. Bit 1 selects active-low. Both reset to 0.
  - The line is registered. One cycle after the status, mask and configuration are seen, it shows the OR of status AND NOT mask at the selected polarity.
  - While the line is disabled, it sits at its inactive level: 0 for active-high, 1 for active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | SRC_W | One-cycle event pulses, one per source position |
| rd_en_i | input | 1 | Read strobe for the register port |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after the read strobe |
| host_irq_o | output | 1 | Registered host interrupt line |

## Verification
A new source pulse can land in the same cycle as a clear of the same bit. The clear can come from an acknowledge write or from a read of the view that clears on read. The bench drives both collisions on purpose: it raises the pulse in the very cycle that carries the acknowledge write or the clearing read. It then judges the outcome with a follow-up read of the view with no side effects, which must still show the bit. A behavioural model also mirrors every cycle, and its read data and line level are compared against the design on each clock, so an ordering error shows up at once.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;

  // Register offsets seen by the host port
  typedef enum logic [2:0] {
    RA_MASK   = 3'd0,
    RA_MSET   = 3'd1,
    RA_MCLR   = 3'd2,
    RA_PEEK   = 3'd3,
    RA_TAKE   = 3'd4,
    RA_ACK    = 3'd5,
    RA_PINCFG = 3'd6
  } reg_addr_e;

  // Output line configuration: bit 1 active-low, bit 0 enable
  typedef struct packed {
    logic act_low;
    logic enable;
  } pin_cfg_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned      W     = 18,
  parameter logic [W-1:0]     VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (VALID[b]) begin : g_live
      logic bit_q;
      // a fresh event overrides a clear in the same cycle
      always_ff @(posedge clk_i) begin
        if (rst_i)          bit_q <= 1'b0;
        else if (src_i[b])  bit_q <= 1'b1;
        else if (clr_i[b])  bit_q <= 1'b0;
      end
      assign status_o[b] = bit_q;
    end else begin : g_rsv
      logic unused_in;
      assign unused_in   = src_i[b] ^ clr_i[b];
      assign status_o[b] = 1'b0;
    end
  end

  // R9
  event_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(src_i & VALID)) |=> ((status_o & $past(src_i & VALID)) == $past(src_i & VALID)));

  // R8
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(clr_i & ~src_i)) |=> ((status_o & $past(clr_i & ~src_i)) == '0));

  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned  W     = 18,
  parameter logic [W-1:0] VALID = '1,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_full_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = wr_set_i ? wdata_i : '0;
  assign clr_bits = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i)          mask_q <= INIT & VALID;
    else if (wr_full_i) mask_q <= wdata_i & VALID;
    else                mask_q <= (mask_q | set_bits) & ~clr_bits & VALID;
  end

  assign mask_o = mask_q;

  // R4
  mask_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_set_i |=> ((mask_o & $past(wdata_i & VALID)) == $past(wdata_i & VALID)));

  // R4
  mask_set_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_set_i |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

  // R5
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_clr_i |=> ((mask_o & $past(wdata_i)) == '0));

  // R5
  mask_clr_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_clr_i |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  input  logic         enable_i,
  input  logic         act_low_i,
  output logic         pin_o
);

  logic pending;
  logic pin_q;

  assign pending = |(status_i & ~mask_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)         pin_q <= 1'b0;
    else if (enable_i) pin_q <= pending ^ act_low_i;
    else               pin_q <= act_low_i;
  end

  assign pin_o = pin_q;

  // R10
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !enable_i |=> (pin_o == $past(act_low_i)));

  // R3
  pin_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && ((status_i & ~mask_i) == '0)) |=> (pin_o == $past(act_low_i)));

  // R10
  pin_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && ((status_i & ~mask_i) != '0)) |=> (pin_o == !$past(act_low_i)));

endmodule

// File: rtl/host_irq_agg.sv
module host_irq_agg
  import host_irq_pkg::*;
#(
  parameter int unsigned      SRC_W     = 18,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      ADDR_W    = 3,
  parameter logic [SRC_W-1:0] VALID_MAP = 18'h347FF,
  parameter logic [SRC_W-1:0] MASK_INIT = 18'h00001
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              host_irq_o
);

  localparam int unsigned CFG_W = $bits(pin_cfg_t);

  logic [SRC_W-1:0]  wbits;
  logic [SRC_W-1:0]  status;
  logic [SRC_W-1:0]  mask;
  logic [SRC_W-1:0]  clr_vec;
  logic              hit_mask, hit_mset, hit_mclr, hit_peek, hit_take, hit_ack, hit_cfg;
  logic              wr_cfg;
  pin_cfg_t          cfg_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata_hi;

  assign wbits           = wdata_i[SRC_W-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:SRC_W];

  // address decode
  assign hit_mask = (addr_i == ADDR_W'(RA_MASK));
  assign hit_mset = (addr_i == ADDR_W'(RA_MSET));
  assign hit_mclr = (addr_i == ADDR_W'(RA_MCLR));
  assign hit_peek = (addr_i == ADDR_W'(RA_PEEK));
  assign hit_take = (addr_i == ADDR_W'(RA_TAKE));
  assign hit_ack  = (addr_i == ADDR_W'(RA_ACK));
  assign hit_cfg  = (addr_i == ADDR_W'(RA_PINCFG));
  assign wr_cfg   = wr_en_i && hit_cfg;

  // both retire paths merge into one clear vector
  assign clr_vec = ((wr_en_i && hit_ack) ? wbits : '0)
                 | ((rd_en_i && hit_take) ? '1 : '0);

  irq_status_bank #(.W(SRC_W), .VALID(VALID_MAP)) u_status (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .src_i    (src_i),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  irq_mask_reg #(.W(SRC_W), .VALID(VALID_MAP), .INIT(MASK_INIT)) u_mask (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_full_i (wr_en_i && hit_mask),
    .wr_set_i  (wr_en_i && hit_mset),
    .wr_clr_i  (wr_en_i && hit_mclr),
    .wdata_i   (wbits),
    .mask_o    (mask)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)       cfg_q <= '0;
    else if (wr_cfg) cfg_q <= pin_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  irq_pin_drive #(.W(SRC_W)) u_pin (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .status_i  (status),
    .mask_i    (mask),
    .enable_i  (cfg_q.enable),
    .act_low_i (cfg_q.act_low),
    .pin_o     (host_irq_o)
  );

  // read mux; write-only and unused offsets return zero
  always_comb begin
    rd_val = '0;
    if (hit_mask)               rd_val = DATA_W'(mask);
    else if (hit_peek || hit_take) rd_val = DATA_W'(status);
    else if (hit_cfg)           rd_val = DATA_W'(cfg_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R2
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> (rdata_o == '0));

  // R7
  take_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && hit_take && (src_i == '0)) |=> (status == '0));

  // R6
  peek_keeps_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && hit_peek && !wr_en_i && (src_i == '0)) |=> (status == $past(status)));

  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_en_i |=> ((rdata_o[SRC_W-1:0] & ~VALID_MAP) == '0));

endmodule

// File: tb/host_irq_agg_test.sv
module host_irq_agg_test;

  localparam logic [17:0] V = 18'h347FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] src = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";

  always #2 clk = ~clk; // 250 MHz

  host_irq_agg uut (
    .clk_i(clk), .rst_i(rst), .src_i(src), .rd_en_i(rd), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .host_irq_o(irq)
  );

  // behavioural reference, advanced on every clock
  logic [17:0] m_status, m_mask;
  logic [1:0]  m_cfg;
  logic [31:0] m_rdata;
  logic        m_pin;

  always @(posedge clk) begin : model
    logic [17:0] ns, nm, clr;
    logic [31:0] rv;
    logic        np;
    logic [1:0]  nc;
    if (rst) begin
      m_status = '0; m_mask = 18'h1; m_cfg = '0; m_rdata = '0; m_pin = 1'b0;
    end else begin
      np = m_cfg[0] ? ((|(m_status & ~m_mask)) ^ m_cfg[1]) : m_cfg[1];
      rv = '0;
      if (rd) begin
        if (addr == 0) rv = {14'd0, m_mask};
        else if (addr == 3 || addr == 4) rv = {14'd0, m_status};
        else if (addr == 6) rv = {30'd0, m_cfg};
      end
      clr = '0;
      if (wr && addr == 5) clr = clr | wdata[17:0];
      if (rd && addr == 4) clr = '1;
      ns = '0;
      for (int i = 0; i < 18; i++)
        if (V[i]) ns[i] = src[i] ? 1'b1 : (clr[i] ? 1'b0 : m_status[i]);
      nm = m_mask; nc = m_cfg;
      if (wr) begin
        if (addr == 0) nm = wdata[17:0] & V;
        else if (addr == 1) nm = (m_mask | wdata[17:0]) & V;
        else if (addr == 2) nm = m_mask & ~wdata[17:0];
        else if (addr == 6) nc = wdata[1:0];
      end
      m_status = ns; m_mask = nm; m_cfg = nc; m_rdata = rv; m_pin = np;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " rdata cycle"}, rdata, m_rdata);
      chk({cur_req, " line cycle"}, {31'd0, irq}, {31'd0, m_pin});
    end
  end

  task automatic cyc(input logic [17:0] s, input logic r, input logic w,
                     input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    src = s; rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, 3'd0, '0);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    cyc('0, 1'b0, 1'b1, a, d);
    idle(1);
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    cyc('0, 1'b1, 1'b0, a, '0);
    idle(1);
    v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R3";
    rreg(3'd0, v); chk("R3 mask reset", v, 32'h1);
    rreg(3'd3, v); chk("R6 status reset", v, 32'h0);
    rreg(3'd6, v); chk("R10 cfg reset", v, 32'h0);
    chk("R10 line reset", {31'd0, irq}, 32'h0);

    cur_req = "R1";
    cyc(18'h3FFFF, 1'b0, 1'b0, 3'd0, '0); idle(1);
    rreg(3'd3, v); chk("R1 valid map", v, 32'h347FF);
    rreg(3'd3, v); chk("R6 peek repeat", v, 32'h347FF);
    rreg(3'd0, v); chk("R1 mask reserved", v, 32'h1);

    cur_req = "R10";
    chk("R10 disabled line", {31'd0, irq}, 32'h0);
    wreg(3'd6, 32'h1); idle(2);
    chk("R10 enabled high", {31'd0, irq}, 32'h1);
    wreg(3'd6, 32'h3); idle(2);
    chk("R10 enabled low", {31'd0, irq}, 32'h0);
    wreg(3'd6, 32'h1);

    cur_req = "R8";
    wreg(3'd5, 32'h3);
    rreg(3'd3, v); chk("R8 ack", v, 32'h347FC);
    wreg(3'd5, 32'h0);
    rreg(3'd3, v); chk("R8 ack zero", v, 32'h347FC);

    cur_req = "R7";
    rreg(3'd4, v); chk("R7 take value", v, 32'h347FC);
    rreg(3'd3, v); chk("R7 after take", v, 32'h0);
    idle(2);
    chk("R7 line drops", {31'd0, irq}, 32'h0);

    cur_req = "R3";
    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, v); chk("R3 full write", v, 32'h347FF);
    cyc(18'h4, 1'b0, 1'b0, 3'd0, '0); idle(3);
    chk("R3 masked line", {31'd0, irq}, 32'h0);

    cur_req = "R5";
    wreg(3'd2, 32'h4); idle(1);
    rreg(3'd0, v); chk("R5 clear bit", v, 32'h347FB);
    chk("R5 line unmasked", {31'd0, irq}, 32'h1);
    wreg(3'd0, 32'h0);

    cur_req = "R4";
    wreg(3'd1, 32'h10);
    rreg(3'd0, v); chk("R4 set bit", v, 32'h10);
    wreg(3'd1, 32'h0);
    rreg(3'd0, v); chk("R4 set zero", v, 32'h10);
    wreg(3'd2, 32'h0);
    rreg(3'd0, v); chk("R5 clear zero", v, 32'h10);
    rreg(3'd1, v); chk("R2 write-only reads zero", v, 32'h0);
    wreg(3'd5, 32'h4);

    cur_req = "R9";
    cyc(18'h20, 1'b0, 1'b0, 3'd0, '0); idle(1);
    cyc(18'h20, 1'b0, 1'b1, 3'd5, 32'h20); idle(1);
    rreg(3'd3, v); chk("R9 pulse beats ack", v, 32'h20);
    cyc(18'h80, 1'b1, 1'b0, 3'd4, '0); idle(1);
    chk("R9 take returns old", rdata, 32'h20);
    rreg(3'd3, v); chk("R9 pulse beats take", v, 32'h80);
    idle(10);
    rreg(3'd3, v); chk("R9 sticky", v, 32'h80);

    cur_req = "R1";
    cyc(18'h0B800, 1'b0, 1'b0, 3'd0, '0); idle(1);
    rreg(3'd3, v); chk("R1 reserved ignored", v, 32'h80);

    cur_req = "R10";
    wreg(3'd6, 32'h0); idle(2);
    chk("R10 off active-high", {31'd0, irq}, 32'h0);
    wreg(3'd6, 32'h2); idle(2);
    chk("R10 off active-low", {31'd0, irq}, 32'h1);

    cur_req = "R2";
    rreg(3'd5, v); chk("R2 ack reads zero", v, 32'h0);
    rreg(3'd7, v); chk("R2 spare reads zero", v, 32'h0);
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule